// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a target FPGA through its slave-serial configuration pins. It drives an active-low program strobe, a configuration clock and a serial data line. It watches two pins from the target: an active-low init/ready flag and a done flag. A single-cycle start request opens a three-phase handshake. First the program strobe is pulled low until the target signals that it has cleared. Then the strobe is released until the target signals that it is ready for data. Data words are then accepted on a valid/ready port and shifted out bit by bit. A word carrying the end-of-data flag moves the block into the final phase, where it waits for the done flag.

Every wait is judged on a slow poll tick of `TICK_CYC` system clocks. A phase that sees the wrong level on more than `POLL_LIMIT` consecutive polls ends the attempt with its own result code. The clock and data pins follow a four-step pattern per bit, so that data only moves to a new value while the configuration clock is low. The outcome stays on the result port until the next start. The two target inputs are resynchronised over `SYNC_STAGES` flops before the sequencer looks at them.

Top module: `cfg_serial_seq`

## Requirements
- R1: After reset, and whenever no attempt is running, prog_n_o, cclk_o and dout_o are 1, busy_o is 0 and in_ready_o is 0. After reset, result_valid_o is also 0.
- R2: start_i high while idle is taken at that clock edge. From the next cycle busy_o is 1 and prog_n_o is 0, with cclk_o and dout_o still 1.
- R3: The poll tick fires every TICK_CYC cycles, with the first tick TICK_CYC cycles after a phase begins. If init_n_i (after synchronisation) reads 1 on POLL_LIMIT+1 consecutive ticks of the program phase, the attempt ends with result_code_o = 1. busy_o is then high for exactly (POLL_LIMIT+1)*TICK_CYC cycles.
- R4: A tick that reads init_n_i = 0 in the program phase raises prog_n_o in the next cycle. The block then waits for init_n_i = 1 under the same poll scheme, and on timeout ends with result_code_o = 2.
- R5: Each bit is four steps of STEP_CYC cycles each: clock low with data 1; clock low with data = bit; clock high with data = bit; clock high with data 1. cclk_o is therefore low for exactly 2*STEP_CYC cycles per bit.
- R6: Each WORD_W-bit word is sent most significant bit first. dout_o does not change in the cycle cclk_o rises, and it is 1 in the cycle cclk_o falls.
- R7: After the word marked with in_last_i has been fully sent, done_i is polled under the same scheme. Done seen gives result_code_o = 0; a timeout gives result_code_o = 3.
- R8: When the awaited level first appears on the very tick that would otherwise be the timeout poll, the phase advances and no error is reported.
- R9: start_i is ignored while busy_o is 1. The program strobe stays high and the transfer in progress continues unchanged.
- R10: in_ready_o is 1 only in the data phase, and only while no word is being shifted.
- R11: result_valid_o goes to 1 together with busy_o falling. It holds its code until the next accepted start, which clears it. It is never 1 while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration attempt (taken when idle) |
| in_valid_i | input | 1 | Data word offered |
| in_data_i | input | WORD_W | Data word, sent MSB first |
| in_last_i | input | 1 | Marks the final word of the stream |
| in_ready_o | output | 1 | Word accepted when high together with in_valid_i |
| init_n_i | input | 1 | Target init flag, low while clearing, high when ready |
| done_i | input | 1 | Target configuration done flag |
| prog_n_o | output | 1 | Active-low program strobe to target |
| cclk_o | output | 1 | Configuration clock to target |
| dout_o | output | 1 | Serial configuration data to target |
| busy_o | output | 1 | Attempt in progress |
| result_valid_o | output | 1 | Result code is valid |
| result_code_o | output | 2 | 0 ok, 1 init not cleared, 2 init not released, 3 done missing |

## Verification
The poll that would declare a timeout and the arrival of the awaited level can land on the same tick. The block must then treat it as success. The bench provokes this by holding init_n_i high through the first POLL_LIMIT polls of the program phase. It then drops init_n_i just early enough that, after the synchroniser, the new level reaches the sequencer exactly on the final poll. The attempt is judged by its result code and by the exact number of busy cycles: a correct block advances and later times out in the release phase with code 2 after twice the single-phase window, whereas a block that lets the timeout win reports code 1 after one window.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_PULSE   = 3'd1,
        SEQ_RECOVER = 3'd2,
        SEQ_STREAM  = 3'd3,
        SEQ_CONFIRM = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_NO_CLEAR = 2'd1,
        RES_NO_READY = 2'd2,
        RES_NO_DONE  = 2'd3
    } result_e;

    typedef enum logic [2:0] {
        BIT_IDLE    = 3'd0,
        BIT_LOW     = 3'd1,
        BIT_SETUP   = 3'd2,
        BIT_HIGH    = 3'd3,
        BIT_RESTORE = 3'd4
    } bit_step_e;

endpackage

// File: rtl/cfg_in_sync.sv
module cfg_in_sync #(
    parameter int unsigned       WIDTH       = 2,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0]  RST_VAL     = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [SYNC_STAGES-1:0][WIDTH-1:0] chain_d;
    logic [SYNC_STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {SYNC_STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
    parameter int unsigned TICK_CYC = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);

    localparam int unsigned CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_regs_t;

    tick_regs_t tick_d;
    tick_regs_t tick_q;

    always_comb begin
        tick_d = tick_q;
        tick   = (tick_q.cnt == LAST);
        if (restart || tick) begin
            tick_d.cnt = '0;
        end else begin
            tick_d.cnt = tick_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_d;
        end
    end

endmodule

// File: rtl/cfg_poll_watch.sv
module cfg_poll_watch #(
    parameter int unsigned POLL_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic tick,
    input  logic cond,
    output logic met,
    output logic expired
);

    localparam int unsigned MW = (POLL_LIMIT > 0) ? $clog2(POLL_LIMIT + 1) : 1;
    localparam logic [MW-1:0] LIM = MW'(POLL_LIMIT);

    typedef struct packed {
        logic [MW-1:0] miss;
    } poll_regs_t;

    poll_regs_t poll_d;
    poll_regs_t poll_q;

    logic at_limit;

    always_comb begin
        poll_d   = poll_q;
        at_limit = (poll_q.miss == LIM);
        // a level seen on a tick always wins over the timeout decision
        met      = tick & cond;
        expired  = tick & ~cond & at_limit;
        if (restart) begin
            poll_d.miss = '0;
        end else if (tick && !cond && !at_limit) begin
            poll_d.miss = poll_q.miss + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q <= '0;
        end else begin
            poll_q <= poll_d;
        end
    end

endmodule

// File: rtl/cfg_bit_driver.sv
module cfg_bit_driver
    import cfg_seq_pkg::*;
#(
    parameter int unsigned WORD_W   = 8,
    parameter int unsigned STEP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              last_in,
    output logic              ready,
    output logic              cclk,
    output logic              dout,
    output logic              word_end,
    output logic              word_last
);

    localparam int unsigned SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam int unsigned IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);
    localparam logic [IW-1:0] BIT_TOP   = IW'(WORD_W - 1);

    typedef struct packed {
        bit_step_e         step;
        logic [SW-1:0]     scnt;
        logic [IW-1:0]     left;
        logic [WORD_W-1:0] sr;
        logic              last;
    } drv_regs_t;

    drv_regs_t drv_d;
    drv_regs_t drv_q;

    logic step_end;

    always_comb begin
        drv_d    = drv_q;
        word_end = 1'b0;
        step_end = (drv_q.scnt == STEP_LAST);

        case (drv_q.step)
            BIT_IDLE: begin
                if (load) begin
                    drv_d.step = BIT_LOW;
                    drv_d.scnt = '0;
                    drv_d.sr   = word;
                    drv_d.left = BIT_TOP;
                    drv_d.last = last_in;
                end
            end
            BIT_LOW: begin
                if (step_end) begin
                    drv_d.scnt = '0;
                    drv_d.step = BIT_SETUP;
                end else begin
                    drv_d.scnt = drv_q.scnt + 1'b1;
                end
            end
            BIT_SETUP: begin
                if (step_end) begin
                    drv_d.scnt = '0;
                    drv_d.step = BIT_HIGH;
                end else begin
                    drv_d.scnt = drv_q.scnt + 1'b1;
                end
            end
            BIT_HIGH: begin
                if (step_end) begin
                    drv_d.scnt = '0;
                    drv_d.step = BIT_RESTORE;
                end else begin
                    drv_d.scnt = drv_q.scnt + 1'b1;
                end
            end
            BIT_RESTORE: begin
                if (step_end) begin
                    drv_d.scnt = '0;
                    if (drv_q.left == '0) begin
                        drv_d.step = BIT_IDLE;
                        word_end   = 1'b1;
                    end else begin
                        drv_d.left = drv_q.left - 1'b1;
                        drv_d.sr   = {drv_q.sr[WORD_W-2:0], 1'b0};
                        drv_d.step = BIT_LOW;
                    end
                end else begin
                    drv_d.scnt = drv_q.scnt + 1'b1;
                end
            end
            default: begin
                drv_d.step = BIT_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    // data only takes the bit value in the two middle steps
    assign ready     = (drv_q.step == BIT_IDLE);
    assign cclk      = (drv_q.step == BIT_IDLE) || (drv_q.step == BIT_HIGH) ||
                       (drv_q.step == BIT_RESTORE);
    assign dout      = ((drv_q.step == BIT_SETUP) || (drv_q.step == BIT_HIGH)) ?
                       drv_q.sr[WORD_W-1] : 1'b1;
    assign word_last = drv_q.last;

endmodule

// File: rtl/cfg_serial_seq.sv
module cfg_serial_seq
    import cfg_seq_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned TICK_CYC    = 100000,
    parameter int unsigned POLL_LIMIT  = 3,
    parameter int unsigned STEP_CYC    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [WORD_W-1:0] in_data_i,
    input  logic              in_last_i,
    output logic              in_ready_o,
    input  logic              init_n_i,
    input  logic              done_i,
    output logic              prog_n_o,
    output logic              cclk_o,
    output logic              dout_o,
    output logic              busy_o,
    output logic              result_valid_o,
    output logic [1:0]        result_code_o
);

    typedef struct packed {
        seq_state_e st;
        logic       res_valid;
        result_e    res_code;
    } seq_regs_t;

    seq_regs_t seq_d;
    seq_regs_t seq_q;

    logic [1:0] pins_sync;
    logic       init_n_s;
    logic       done_s;
    logic       tick;
    logic       restart;
    logic       cond;
    logic       met;
    logic       expired;
    logic       drv_ready;
    logic       drv_cclk;
    logic       drv_dout;
    logic       word_end;
    logic       word_last;
    logic       load;

    cfg_in_sync #(
        .WIDTH       (2),
        .SYNC_STAGES (SYNC_STAGES),
        .RST_VAL     (2'b01)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({done_i, init_n_i}),
        .sync_o  (pins_sync)
    );

    assign init_n_s = pins_sync[0];
    assign done_s   = pins_sync[1];

    cfg_tick_gen #(
        .TICK_CYC (TICK_CYC)
    ) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick)
    );

    always_comb begin
        case (seq_q.st)
            SEQ_PULSE:   cond = ~init_n_s;
            SEQ_RECOVER: cond = init_n_s;
            SEQ_CONFIRM: cond = done_s;
            default:     cond = 1'b0;
        endcase
    end

    cfg_poll_watch #(
        .POLL_LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .cond    (cond),
        .met     (met),
        .expired (expired)
    );

    assign in_ready_o = (seq_q.st == SEQ_STREAM) && drv_ready;
    assign load       = in_valid_i && in_ready_o;

    cfg_bit_driver #(
        .WORD_W   (WORD_W),
        .STEP_CYC (STEP_CYC)
    ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word      (in_data_i),
        .last_in   (in_last_i),
        .ready     (drv_ready),
        .cclk      (drv_cclk),
        .dout      (drv_dout),
        .word_end  (word_end),
        .word_last (word_last)
    );

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st        = SEQ_PULSE;
                    seq_d.res_valid = 1'b0;
                end
            end
            SEQ_PULSE: begin
                if (met) begin
                    seq_d.st = SEQ_RECOVER;
                end else if (expired) begin
                    seq_d.st        = SEQ_IDLE;
                    seq_d.res_valid = 1'b1;
                    seq_d.res_code  = RES_NO_CLEAR;
                end
            end
            SEQ_RECOVER: begin
                if (met) begin
                    seq_d.st = SEQ_STREAM;
                end else if (expired) begin
                    seq_d.st        = SEQ_IDLE;
                    seq_d.res_valid = 1'b1;
                    seq_d.res_code  = RES_NO_READY;
                end
            end
            SEQ_STREAM: begin
                if (word_end && word_last) begin
                    seq_d.st = SEQ_CONFIRM;
                end
            end
            SEQ_CONFIRM: begin
                if (met) begin
                    seq_d.st        = SEQ_IDLE;
                    seq_d.res_valid = 1'b1;
                    seq_d.res_code  = RES_OK;
                end else if (expired) begin
                    seq_d.st        = SEQ_IDLE;
                    seq_d.res_valid = 1'b1;
                    seq_d.res_code  = RES_NO_DONE;
                end
            end
            default: begin
                seq_d.st = SEQ_IDLE;
            end
        endcase
        // every phase change restarts the poll window
        restart = (seq_d.st != seq_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, res_valid: 1'b0, res_code: RES_OK};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign prog_n_o       = (seq_q.st != SEQ_PULSE);
    assign cclk_o         = drv_cclk;
    assign dout_o         = drv_dout;
    assign busy_o         = (seq_q.st != SEQ_IDLE);
    assign result_valid_o = seq_q.res_valid;
    assign result_code_o  = seq_q.res_code;

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic prog_n,
    input logic cclk,
    input logic dout,
    input logic busy,
    input logic in_ready,
    input logic result_valid
);

    // R1: pins rest high whenever no attempt runs
    a_r1_idle_pins_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && cclk && dout));

    // R2: while the strobe is low the clock and data stay high
    a_r2_strobe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n |-> (cclk && dout));

    // R6: data is steady across the rising clock
    a_r6_setup_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(dout));

    // R6: data is back to 1 whenever the clock falls
    a_r6_fall_data_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cclk) |-> dout);

    // R10: words are taken only in the data phase
    a_r10_ready_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (busy && prog_n && cclk));

    // R11: a result is never shown during an attempt
    a_r11_result_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !result_valid);

    // R11: a result appears only as busy falls
    a_r11_result_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $fell(busy));

endmodule

bind cfg_serial_seq cfg_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_n       (prog_n_o),
    .cclk         (cclk_o),
    .dout         (dout_o),
    .busy         (busy_o),
    .in_ready     (in_ready_o),
    .result_valid (result_valid_o)
);

// File: tb/cfg_serial_seq_tb.sv
module cfg_serial_seq_tb;

    localparam int W    = 8;
    localparam int TICK = 6;
    localparam int POLL = 3;
    localparam int STEP = 2;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         in_ready;
    logic         init_n = 1'b1;
    logic         done = 1'b0;
    logic         prog_n;
    logic         cclk;
    logic         dout;
    logic         busy;
    logic         res_valid;
    logic [1:0]   res_code;

    always #2 clk = ~clk;

    cfg_serial_seq #(
        .WORD_W      (W),
        .TICK_CYC    (TICK),
        .POLL_LIMIT  (POLL),
        .STEP_CYC    (STEP),
        .SYNC_STAGES (SYNC)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .in_valid_i     (in_valid),
        .in_data_i      (in_data),
        .in_last_i      (in_last),
        .in_ready_o     (in_ready),
        .init_n_i       (init_n),
        .done_i         (done),
        .prog_n_o       (prog_n),
        .cclk_o         (cclk),
        .dout_o         (dout),
        .busy_o         (busy),
        .result_valid_o (res_valid),
        .result_code_o  (res_code)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected serial bits and line monitor
    logic [0:8191] exp_bits;
    int  wr_idx = 0;
    int  rd_idx = 0;
    logic prev_cclk = 1'b1;
    int  low_run = 0;
    bit  stream_phase = 0;
    int  ready_bad = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!cclk) low_run++;
            if (cclk && !prev_cclk) begin
                check(low_run == 2*STEP, "R5", "clock low length", low_run, 2*STEP);
                check(rd_idx < wr_idx, "R6", "unexpected bit", rd_idx, wr_idx);
                check(dout == exp_bits[rd_idx], "R6", "bit value", int'(dout),
                      int'(exp_bits[rd_idx]));
                rd_idx++;
                low_run = 0;
            end
            prev_cclk = cclk;
            if (in_ready && !stream_phase) ready_bad++;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic bring_up();
        init_n = 1'b1;
        done   = 1'b0;
        pulse_start();
        while (prog_n) @(negedge clk);
        repeat (3) @(negedge clk);
        init_n = 1'b0;
        while (!prog_n) @(negedge clk);
        repeat (3) @(negedge clk);
        init_n = 1'b1;
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] v, input bit last);
        in_valid = 1'b1;
        in_data  = v;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        for (int i = W-1; i >= 0; i--) begin
            exp_bits[wr_idx] = v[i];
            wr_idx++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic check_rest(input string req);
        check(prog_n && cclk && dout, req, "pins high at rest",
              int'({prog_n, cclk, dout}), 7);
        check(!busy && !in_ready, req, "busy/ready low at rest",
              int'({busy, in_ready}), 0);
    endtask

    initial begin
        int cyc;
        int k;

        // reset
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_rest("R1");
        check(!res_valid, "R1", "result invalid after reset", int'(res_valid), 0);

        // init never clears: code 1 after (POLL+1)*TICK busy cycles
        pulse_start();
        check(!prog_n && busy, "R2", "strobe low and busy", int'({prog_n, busy}), 1);
        check(cclk && dout, "R2", "clock/data high in strobe", int'({cclk, dout}), 3);
        wait_idle(cyc);
        check(cyc == (POLL+1)*TICK, "R3", "busy cycles init stuck high", cyc, (POLL+1)*TICK);
        check(res_valid && res_code == 2'd1, "R3", "result code", int'(res_code), 1);
        check_rest("R1");

        // init clears at once but never releases: code 2
        init_n = 1'b0;
        repeat (4) @(negedge clk);
        pulse_start();
        check(!res_valid, "R11", "result cleared by start", int'(res_valid), 0);
        k = 1;
        while (busy) begin
            if (k == TICK) check(!prog_n, "R4", "strobe low before first poll", int'(prog_n), 0);
            if (k == TICK+1) check(prog_n, "R4", "strobe released after poll", int'(prog_n), 1);
            k++;
            @(negedge clk);
        end
        check(k-1 == (POLL+2)*TICK, "R4", "busy cycles release timeout", k-1, (POLL+2)*TICK);
        check(res_valid && res_code == 2'd2, "R4", "result code", int'(res_code), 2);

        // same tick: init arrives on the final poll, must advance (R8)
        init_n = 1'b1;
        repeat (4) @(negedge clk);
        pulse_start();
        k = 1;
        while (busy) begin
            if (k == (POLL+1)*TICK - SYNC) init_n = 1'b0;
            k++;
            @(negedge clk);
        end
        check(k-1 == 2*(POLL+1)*TICK, "R8", "busy cycles on last-poll arrival",
              k-1, 2*(POLL+1)*TICK);
        check(res_code == 2'd2, "R8", "level beats timeout", int'(res_code), 2);
        check(ready_bad == 0, "R10", "ready outside data phase", ready_bad, 0);

        // full byte sweep with a start request in the middle
        bring_up();
        stream_phase = 1;
        for (int v = 0; v < 256; v++) begin
            if (v == 100) begin
                pulse_start();
                check(prog_n && busy, "R9", "start ignored while busy",
                      int'({prog_n, busy}), 3);
            end
            send(v[W-1:0], 1'b0);
        end
        send(8'hA5, 1'b0);
        send(8'h3C, 1'b1);
        stream_phase = 0;
        done = 1'b1;
        wait_idle(cyc);
        check(res_valid && res_code == 2'd0, "R7", "success code", int'(res_code), 0);
        check(rd_idx == wr_idx, "R6", "bit count", rd_idx, wr_idx);
        check_rest("R1");
        repeat (40) @(negedge clk);
        check(res_valid && res_code == 2'd0, "R11", "result held", int'(res_code), 0);
        done = 1'b0;
        repeat (4) @(negedge clk);

        // done never arrives: code 3
        bring_up();
        stream_phase = 1;
        send(8'h81, 1'b1);
        stream_phase = 0;
        wait_idle(cyc);
        check(res_valid && res_code == 2'd3, "R7", "done timeout code", int'(res_code), 3);
        check(rd_idx == wr_idx, "R6", "bit count", rd_idx, wr_idx);
        check(ready_bad == 0, "R10", "ready outside data phase", ready_bad, 0);
        check_rest("R1");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule